// File: doc/BRIEF.md
# NAND Flash Command-Mode Front End

This block is the device-side command interpreter of a byte-wide NAND flash interface. It watches an 8-bit input bus together with chip enable, command-latch enable, address-latch enable and a write strobe. On each completed write strobe it captures a command byte or an address byte. It also keeps an output-mode register that decides what the data bus carries during read cycles: the live status byte, a fixed four-byte identification sequence, or data from the array. All inputs are sampled on one system clock. A write strobe counts at the first clock edge that sees the strobe high after it was low.

The front end handles three commands itself: status read, identification read and reset. The reset command aborts any array operation that is in progress, clears the pass/fail flag and holds the ready/busy output low for a fixed number of cycles. Every other command byte, and every address byte taken in the idle state, is forwarded to the array engines. In this project those engines are a stub driven from the ports. The stub returns a busy level, a completion pulse and a pass/fail flag, and it receives a one-cycle abort pulse.

The controller has three states. In **READY** it accepts commands. In **ID_ADDR** it has seen the identification command and waits for its address byte. In **RESET** it counts down the reset time. The transitions are named as follows:
- **T_ENTER_ID**: command 90h moves READY or ID_ADDR to ID_ADDR.
- **T_ID_DONE**: any address byte moves ID_ADDR to READY, and the mode becomes identification only when that byte is 00h.
- **T_ABANDON**: any command other than 90h or FFh moves ID_ADDR to READY.
- **T_START_RESET**: command FFh moves READY or ID_ADDR to RESET.
- **T_RESET_DONE**: the countdown reaching zero moves RESET to READY.

Top module: `nfc_cmd_frontend`

## Requirements
- R1: A byte is taken at the first clock edge that samples we_n high after it was sampled low, provided ce_n is low. It is a command when cle=1 and ale=0, and an address when ale=1 and cle=0. With ce_n high, or with both latch enables high, nothing is taken. Commands other than 70h, 90h and FFh, and address bytes taken in READY, appear on fwd_byte with a one-cycle fwd_cmd_valid or fwd_addr_valid pulse in the cycle after the capturing edge.
- R2: Command 70h selects status output. io_out then shows the status byte continuously and follows changes in its bits with no read strobe toggling. Status bit 7 = wp_n, bits 6 and 5 = ready (not in reset and array_busy low), bit 0 = fail flag, bits 4..1 = 0.
- R3: An output mode stays in force until another command changes it. Commands other than 00h, 70h, 90h and FFh are forwarded and leave the mode unchanged. Command 00h selects array output, where io_out = array_data.
- R4: Command 90h followed by address 00h selects identification output. io_out shows ADh, DEVICE_ID, ID_BYTE3 and ID_BYTE4 in turn, and advances by one at each edge that samples re_n high after low while ce_n is low.
- R5: Command 90h followed by a nonzero address byte leaves the output mode unchanged.
- R6: Command FFh taken while array_busy is high gives a single-cycle array_abort pulse in the following cycle. Taken while array_busy is low, it gives no pulse.
- R7: ready/busy rb is low for exactly TRST_CYCLES cycles after the edge that takes FFh, and it is also low whenever array_busy is high.
- R8: After a reset completes, the output mode is array and the fail flag is clear, so status reads E0h when wp_n is high and the stub is idle.
- R9: While a reset is in progress every byte is ignored, and a further FFh does not restart or extend the countdown.
- R10: The identification index returns to the first byte on every 90h command, and the read after the fourth byte returns ADh again.
- R11: With wp_n low, status bit 7 reads 0, so status after reset reads 60h.
- R12: The fail flag takes the value of array_fail on each cycle in which array_done is high. Power-on reset and the FFh command clear it.
- R13: io_oe is high exactly when ce_n and re_n are both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous power-on reset |
| ce_n | input | 1 | Chip enable, active low |
| cle | input | 1 | Command latch enable |
| ale | input | 1 | Address latch enable |
| we_n | input | 1 | Write strobe, active low, byte taken on its rise |
| re_n | input | 1 | Read strobe, active low |
| wp_n | input | 1 | Write protect, active low |
| io_in | input | 8 | Byte bus into the device |
| io_out | output | 8 | Byte bus out of the device |
| io_oe | output | 1 | Output enable for io_out |
| rb | output | 1 | Ready/busy, low while busy |
| array_busy | input | 1 | Stub engine is running an operation |
| array_done | input | 1 | Stub engine finished a program or erase (pulse) |
| array_fail | input | 1 | Result of the finished operation, 1 = failed |
| array_data | input | 8 | Array read data from the stub |
| array_abort | output | 1 | Abort request to the stub engine (pulse) |
| fwd_cmd_valid | output | 1 | Forwarded command byte is valid |
| fwd_addr_valid | output | 1 | Forwarded address byte is valid |
| fwd_byte | output | 8 | Forwarded byte |

## Verification
The assertions assume that cle and ale are never both high during a strobe the bench means to be taken. They also assume that the stub raises array_done only while no reset is counting, and that the strobes are slow enough for the clock to see both the low and the high phase of each one. The stimulus drives every bus signal on the falling clock edge, and it holds each strobe level for a whole clock cycle. It drops array_busy right after an abort and pulses array_done only while READY. Because of this, every strobe is seen exactly once, and the reference model in the bench sees the same edges as the design.

// File: rtl/nfc_pkg.sv
`timescale 1ns/1ps
package nfc_pkg;
    typedef enum logic [1:0] {
        ST_READY   = 2'd0,
        ST_ID_ADDR = 2'd1,
        ST_RESET   = 2'd2
    } ctl_state_t;

    typedef enum logic [1:0] {
        OUT_ARRAY  = 2'd0,
        OUT_STATUS = 2'd1,
        OUT_ID     = 2'd2
    } out_mode_t;

    localparam int unsigned BYTE_W   = 8;
    localparam int unsigned ID_COUNT = 4;

    localparam logic [BYTE_W-1:0] OP_READ    = 8'h00;
    localparam logic [BYTE_W-1:0] OP_STATUS  = 8'h70;
    localparam logic [BYTE_W-1:0] OP_READ_ID = 8'h90;
    localparam logic [BYTE_W-1:0] OP_RESET   = 8'hFF;
    localparam logic [BYTE_W-1:0] ID_ADDR_OK = 8'h00;
    localparam logic [BYTE_W-1:0] MAKER_CODE = 8'hAD;
endpackage

// File: rtl/nfc_bus_latch.sv
`timescale 1ns/1ps
module nfc_bus_latch
    import nfc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              cle,
    input  logic              ale,
    input  logic              we_n,
    input  logic [BYTE_W-1:0] io_in,
    output logic              cmd_valid,
    output logic              addr_valid,
    output logic [BYTE_W-1:0] bus_byte
);
    logic we_seen;
    logic strobe_done;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_seen <= 1'b1;
        end else begin
            we_seen <= we_n;
        end
    end

    // A write completes on the first sample of the strobe high after low
    assign strobe_done = we_n & ~we_seen & ~ce_n;
    assign cmd_valid   = strobe_done & cle & ~ale;
    assign addr_valid  = strobe_done & ale & ~cle;
    assign bus_byte    = io_in;
endmodule

// File: rtl/nfc_cmd_fsm.sv
`timescale 1ns/1ps
module nfc_cmd_fsm
    import nfc_pkg::*;
#(
    parameter int unsigned TRST_CYCLES = 50,
    localparam int unsigned CNT_W = $clog2(TRST_CYCLES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic              addr_valid,
    input  logic [BYTE_W-1:0] bus_byte,
    input  logic              array_busy,
    output ctl_state_t        state,
    output out_mode_t         mode,
    output logic [CNT_W-1:0]  rst_cnt,
    output logic              in_reset,
    output logic              id_restart,
    output logic              clear_fail,
    output logic              array_abort,
    output logic              fwd_cmd_valid,
    output logic              fwd_addr_valid,
    output logic [BYTE_W-1:0] fwd_byte
);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(TRST_CYCLES - 1);

    ctl_state_t       state_nx;
    out_mode_t        mode_nx;
    logic [CNT_W-1:0] cnt_nx;
    logic             accepting;
    logic             take_reset;
    logic             handled_here;

    assign accepting    = (state != ST_RESET);
    assign take_reset   = accepting & cmd_valid & (bus_byte == OP_RESET);
    assign handled_here = (bus_byte == OP_STATUS) | (bus_byte == OP_READ_ID) |
                          (bus_byte == OP_RESET);
    assign id_restart   = accepting & cmd_valid & (bus_byte == OP_READ_ID);
    assign clear_fail   = take_reset;
    assign in_reset     = (state == ST_RESET);

    // Next-state logic
    always_comb begin
        state_nx = state;
        mode_nx  = mode;
        cnt_nx   = rst_cnt;
        unique case (state)
            ST_READY, ST_ID_ADDR: begin
                if (cmd_valid) begin
                    if (bus_byte == OP_RESET) begin
                        state_nx = ST_RESET;          // T_START_RESET
                        cnt_nx   = CNT_LOAD;
                        mode_nx  = OUT_ARRAY;
                    end else if (bus_byte == OP_READ_ID) begin
                        state_nx = ST_ID_ADDR;        // T_ENTER_ID
                    end else if (bus_byte == OP_STATUS) begin
                        state_nx = ST_READY;          // T_ABANDON when in ID_ADDR
                        mode_nx  = OUT_STATUS;
                    end else if (bus_byte == OP_READ) begin
                        state_nx = ST_READY;
                        mode_nx  = OUT_ARRAY;
                    end else begin
                        state_nx = ST_READY;
                    end
                end else if (addr_valid && state == ST_ID_ADDR) begin
                    state_nx = ST_READY;              // T_ID_DONE
                    if (bus_byte == ID_ADDR_OK) begin
                        mode_nx = OUT_ID;
                    end
                end
            end
            ST_RESET: begin
                if (rst_cnt == '0) begin
                    state_nx = ST_READY;              // T_RESET_DONE
                end else begin
                    cnt_nx = rst_cnt - 1'b1;
                end
            end
            default: begin
                state_nx = ST_READY;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_READY;
            mode    <= OUT_ARRAY;
            rst_cnt <= '0;
        end else begin
            state   <= state_nx;
            mode    <= mode_nx;
            rst_cnt <= cnt_nx;
        end
    end

    // Registered outputs to the array engines
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            array_abort    <= 1'b0;
            fwd_cmd_valid  <= 1'b0;
            fwd_addr_valid <= 1'b0;
            fwd_byte       <= '0;
        end else begin
            array_abort    <= take_reset & array_busy;
            fwd_cmd_valid  <= accepting & cmd_valid & ~handled_here;
            fwd_addr_valid <= (state == ST_READY) & addr_valid & ~cmd_valid;
            fwd_byte       <= bus_byte;
        end
    end
endmodule

// File: rtl/nfc_status_reg.sv
`timescale 1ns/1ps
module nfc_status_reg
    import nfc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wp_n,
    input  logic              ready,
    input  logic              array_done,
    input  logic              array_fail,
    input  logic              clear_fail,
    output logic [BYTE_W-1:0] status_byte
);
    logic fail_flag;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fail_flag <= 1'b0;
        end else if (clear_fail) begin
            fail_flag <= 1'b0;
        end else if (array_done) begin
            fail_flag <= array_fail;
        end
    end

    assign status_byte = {wp_n, ready, ready, 4'b0000, fail_flag};
endmodule

// File: rtl/nfc_read_mux.sv
`timescale 1ns/1ps
module nfc_read_mux
    import nfc_pkg::*;
#(
    parameter logic [BYTE_W-1:0] DEVICE_ID = 8'hD5,
    parameter logic [BYTE_W-1:0] ID_BYTE3  = 8'h14,
    parameter logic [BYTE_W-1:0] ID_BYTE4  = 8'hB6,
    localparam int unsigned IDX_W = $clog2(ID_COUNT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              re_n,
    input  out_mode_t         mode,
    input  logic              id_restart,
    input  logic [BYTE_W-1:0] status_byte,
    input  logic [BYTE_W-1:0] array_data,
    output logic [BYTE_W-1:0] io_out,
    output logic [IDX_W-1:0]  id_index
);
    logic              re_seen;
    logic              read_done;
    logic [BYTE_W-1:0] id_tab [ID_COUNT];

    function automatic logic [BYTE_W-1:0] id_entry(input int unsigned k);
        case (k)
            0:       return MAKER_CODE;
            1:       return DEVICE_ID;
            2:       return ID_BYTE3;
            default: return ID_BYTE4;
        endcase
    endfunction

    for (genvar g = 0; g < ID_COUNT; g++) begin : g_id
        assign id_tab[g] = id_entry(g);
    end

    assign read_done = re_n & ~re_seen & ~ce_n;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            re_seen  <= 1'b1;
            id_index <= '0;
        end else begin
            re_seen <= re_n;
            if (id_restart) begin
                id_index <= '0;
            end else if (mode == OUT_ID && read_done) begin
                id_index <= (id_index == IDX_W'(ID_COUNT - 1)) ? '0 : id_index + 1'b1;
            end
        end
    end

    always_comb begin
        unique case (mode)
            OUT_STATUS: io_out = status_byte;
            OUT_ID:     io_out = id_tab[id_index];
            default:    io_out = array_data;
        endcase
    end
endmodule

// File: rtl/nfc_cmd_frontend.sv
`timescale 1ns/1ps
module nfc_cmd_frontend
    import nfc_pkg::*;
#(
    parameter int unsigned       TRST_CYCLES = 50,
    parameter logic [7:0]        DEVICE_ID   = 8'hD5,
    parameter logic [7:0]        ID_BYTE3    = 8'h14,
    parameter logic [7:0]        ID_BYTE4    = 8'hB6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ce_n,
    input  logic       cle,
    input  logic       ale,
    input  logic       we_n,
    input  logic       re_n,
    input  logic       wp_n,
    input  logic [7:0] io_in,
    output logic [7:0] io_out,
    output logic       io_oe,
    output logic       rb,
    input  logic       array_busy,
    input  logic       array_done,
    input  logic       array_fail,
    input  logic [7:0] array_data,
    output logic       array_abort,
    output logic       fwd_cmd_valid,
    output logic       fwd_addr_valid,
    output logic [7:0] fwd_byte
);
    localparam int unsigned CNT_W = $clog2(TRST_CYCLES + 1);
    localparam int unsigned IDX_W = $clog2(ID_COUNT);

    logic              cmd_valid;
    logic              addr_valid;
    logic [BYTE_W-1:0] bus_byte;
    ctl_state_t        state;
    out_mode_t         mode;
    logic [CNT_W-1:0]  rst_cnt;
    logic              in_reset;
    logic              id_restart;
    logic              clear_fail;
    logic [BYTE_W-1:0] status_byte;
    logic [IDX_W-1:0]  id_index;

    assign rb    = ~in_reset & ~array_busy;
    assign io_oe = ~ce_n & ~re_n;

    nfc_bus_latch u_latch (
        .clk        (clk),
        .rst_n      (rst_n),
        .ce_n       (ce_n),
        .cle        (cle),
        .ale        (ale),
        .we_n       (we_n),
        .io_in      (io_in),
        .cmd_valid  (cmd_valid),
        .addr_valid (addr_valid),
        .bus_byte   (bus_byte)
    );

    nfc_cmd_fsm #(.TRST_CYCLES(TRST_CYCLES)) u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .cmd_valid      (cmd_valid),
        .addr_valid     (addr_valid),
        .bus_byte       (bus_byte),
        .array_busy     (array_busy),
        .state          (state),
        .mode           (mode),
        .rst_cnt        (rst_cnt),
        .in_reset       (in_reset),
        .id_restart     (id_restart),
        .clear_fail     (clear_fail),
        .array_abort    (array_abort),
        .fwd_cmd_valid  (fwd_cmd_valid),
        .fwd_addr_valid (fwd_addr_valid),
        .fwd_byte       (fwd_byte)
    );

    nfc_status_reg u_status (
        .clk         (clk),
        .rst_n       (rst_n),
        .wp_n        (wp_n),
        .ready       (rb),
        .array_done  (array_done),
        .array_fail  (array_fail),
        .clear_fail  (clear_fail),
        .status_byte (status_byte)
    );

    nfc_read_mux #(
        .DEVICE_ID (DEVICE_ID),
        .ID_BYTE3  (ID_BYTE3),
        .ID_BYTE4  (ID_BYTE4)
    ) u_rdmux (
        .clk         (clk),
        .rst_n       (rst_n),
        .ce_n        (ce_n),
        .re_n        (re_n),
        .mode        (mode),
        .id_restart  (id_restart),
        .status_byte (status_byte),
        .array_data  (array_data),
        .io_out      (io_out),
        .id_index    (id_index)
    );
endmodule

// File: rtl/nfc_cmd_checker.sv
`timescale 1ns/1ps
module nfc_cmd_checker
    import nfc_pkg::*;
#(
    parameter int unsigned CNT_W = 6,
    parameter int unsigned IDX_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ce_n,
    input logic             wp_n,
    input logic             rb,
    input logic [7:0]       io_out,
    input logic             array_busy,
    input logic             array_abort,
    input logic             cmd_valid,
    input logic             addr_valid,
    input logic             in_reset,
    input logic [CNT_W-1:0] rst_cnt,
    input out_mode_t        mode,
    input logic             id_restart,
    input logic [IDX_W-1:0] id_index
);
    AST_CE_HIGH_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |-> (!cmd_valid && !addr_valid)); // R1

    AST_STATUS_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == OUT_STATUS) |-> (io_out[7] == wp_n && io_out[6] == rb && io_out[4:1] == 4'b0)); // R2

    AST_ABORT_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        array_abort |-> $past(array_busy)); // R6

    AST_ABORT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        array_abort |=> !array_abort); // R6

    AST_RESET_RB_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        in_reset |-> !rb); // R7

    AST_RESET_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (in_reset && $past(in_reset)) |-> (rst_cnt == CNT_W'($past(rst_cnt) - 1'b1))); // R9

    AST_RESET_ENDS_ARRAY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(in_reset) |-> (mode == OUT_ARRAY)); // R8

    AST_ID_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        id_restart |=> (id_index == '0)); // R10
endmodule

bind nfc_cmd_frontend nfc_cmd_checker #(.CNT_W(CNT_W), .IDX_W(IDX_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ce_n        (ce_n),
    .wp_n        (wp_n),
    .rb          (rb),
    .io_out      (io_out),
    .array_busy  (array_busy),
    .array_abort (array_abort),
    .cmd_valid   (cmd_valid),
    .addr_valid  (addr_valid),
    .in_reset    (in_reset),
    .rst_cnt     (rst_cnt),
    .mode        (mode),
    .id_restart  (id_restart),
    .id_index    (id_index)
);

// File: tb/sim_nfc_cmd_frontend.sv
`timescale 1ns/1ps
module sim_nfc_cmd_frontend;
    localparam int TRST = 12;
    localparam logic [7:0] DEV = 8'hD3;
    localparam logic [7:0] B3  = 8'h51;
    localparam logic [7:0] B4  = 8'h95;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ce_n = 1'b1, cle = 1'b0, ale = 1'b0, we_n = 1'b1, re_n = 1'b1, wp_n = 1'b1;
    logic [7:0] io_in = 8'h00;
    logic [7:0] io_out;
    logic io_oe, rb;
    logic array_busy = 1'b0, array_done = 1'b0, array_fail = 1'b0;
    logic [7:0] array_data = 8'h3C;
    logic array_abort, fwd_cmd_valid, fwd_addr_valid;
    logic [7:0] fwd_byte;

    int checks = 0;
    int failures = 0;
    bit finished = 0;
    int low_cnt = 0;

    always #10 clk = ~clk;

    nfc_cmd_frontend #(.TRST_CYCLES(TRST), .DEVICE_ID(DEV), .ID_BYTE3(B3), .ID_BYTE4(B4)) u0 (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cle(cle), .ale(ale), .we_n(we_n),
        .re_n(re_n), .wp_n(wp_n), .io_in(io_in), .io_out(io_out), .io_oe(io_oe),
        .rb(rb), .array_busy(array_busy), .array_done(array_done),
        .array_fail(array_fail), .array_data(array_data), .array_abort(array_abort),
        .fwd_cmd_valid(fwd_cmd_valid), .fwd_addr_valid(fwd_addr_valid), .fwd_byte(fwd_byte)
    );

    // ---------------- reference model ----------------
    int m_mode = 0;       // 0 array, 1 status, 2 id
    int m_idx = 0;
    int m_rst = 0;        // cycles of reset left
    bit m_fail = 0;
    bit m_idwait = 0;
    bit p_we = 1, p_re = 1;
    bit e_abort = 0, e_fc = 0, e_fa = 0;
    logic [7:0] e_fb = 8'h00;

    function automatic logic [7:0] id_byte(input int k);
        case (k)
            0: return 8'hAD;
            1: return DEV;
            2: return B3;
            default: return B4;
        endcase
    endfunction

    function automatic logic [7:0] exp_out();
        bit rdy;
        rdy = (m_rst == 0) && !array_busy;
        if (m_mode == 1) return {wp_n, rdy, rdy, 4'b0000, m_fail};
        if (m_mode == 2) return id_byte(m_idx);
        return array_data;
    endfunction

    always @(posedge clk) begin
        bit wr, is_c, is_a, rd, busy_now;
        if (!rst_n) begin
            m_mode = 0; m_idx = 0; m_rst = 0; m_fail = 0; m_idwait = 0;
            p_we = 1; p_re = 1; e_abort = 0; e_fc = 0; e_fa = 0;
        end else begin
            wr   = we_n && !p_we && !ce_n;
            is_c = wr && cle && !ale;
            is_a = wr && ale && !cle;
            rd   = re_n && !p_re && !ce_n;
            busy_now = (m_rst > 0);
            e_abort = 0; e_fc = 0; e_fa = 0; e_fb = io_in;
            if (array_done) m_fail = array_fail;
            if (m_mode == 2 && rd) m_idx = (m_idx + 1) % 4;
            if (busy_now) begin
                m_rst = m_rst - 1;
            end else if (is_c) begin
                case (io_in)
                    8'hFF: begin m_rst = TRST; e_abort = array_busy; m_fail = 0; m_mode = 0; m_idwait = 0; end
                    8'h70: begin m_mode = 1; m_idwait = 0; end
                    8'h90: begin m_idwait = 1; m_idx = 0; end
                    8'h00: begin m_mode = 0; m_idwait = 0; e_fc = 1; end
                    default: begin m_idwait = 0; e_fc = 1; end
                endcase
            end else if (is_a) begin
                if (m_idwait) begin
                    if (io_in == 8'h00) m_mode = 2;
                    m_idwait = 0;
                end else begin
                    e_fa = 1;
                end
            end
            p_we = we_n; p_re = re_n;
        end
    end

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare every cycle, 5 ns after the rising edge
    always @(posedge clk) begin
        #5;
        if (rst_n && !finished) begin
            if (!rb) low_cnt++;
            chk(m_mode == 1 ? "R2 status out" : (m_mode == 2 ? "R4 id out" : "R3 array out"),
                io_out, exp_out());
            chk("R7 rb", {7'b0, rb}, {7'b0, (m_rst == 0) && !array_busy});
            chk("R13 io_oe", {7'b0, io_oe}, {7'b0, !ce_n && !re_n});
            chk("R6 abort", {7'b0, array_abort}, {7'b0, e_abort});
            chk("R1 fwd_cmd", {7'b0, fwd_cmd_valid}, {7'b0, e_fc});
            chk("R1 fwd_addr", {7'b0, fwd_addr_valid}, {7'b0, e_fa});
            if (e_fc || e_fa) chk("R1 fwd_byte", fwd_byte, e_fb);
        end
    end

    // ---------------- stimulus ----------------
    task automatic put_byte(input bit as_addr, input logic [7:0] b, input bit ce_high);
        @(negedge clk);
        ce_n = ce_high; cle = !as_addr; ale = as_addr; io_in = b; we_n = 1'b0;
        @(negedge clk);
        we_n = 1'b1;
        @(negedge clk);
        cle = 1'b0; ale = 1'b0; ce_n = 1'b0;
    endtask

    task automatic rd_cycle();
        @(negedge clk); re_n = 1'b0;
        @(negedge clk); re_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(2);
        chk("R3 reset state array", io_out, 8'h3C);
        chk("R7 reset state rb", {7'b0, rb}, 8'h01);

        // status mode and live update
        put_byte(0, 8'h70, 0);
        chk("R2 status after power-on", io_out, 8'hE0);
        array_busy = 1'b1;
        idle(2);
        chk("R2 live busy", io_out, 8'h80);
        array_busy = 1'b0; array_done = 1'b1; array_fail = 1'b1;
        @(negedge clk); array_done = 1'b0; array_fail = 1'b0;
        idle(1);
        chk("R12 fail latched", io_out, 8'hE1);

        // other command keeps mode, 00h returns to array
        put_byte(0, 8'h80, 0);
        put_byte(1, 8'h12, 0);
        chk("R3 mode kept", io_out, 8'hE1);
        put_byte(0, 8'h00, 0);
        array_data = 8'h5A;
        idle(1);
        chk("R3 array after 00h", io_out, 8'h5A);

        // identification sequence with wrap and restart
        put_byte(0, 8'h90, 0);
        put_byte(1, 8'h00, 0);
        for (int k = 0; k < 5; k++) begin
            chk(k == 4 ? "R10 wrap" : "R4 id byte", io_out, id_byte(k % 4));
            rd_cycle();
        end
        rd_cycle();
        put_byte(0, 8'h90, 0);
        put_byte(1, 8'h00, 0);
        chk("R10 restart", io_out, 8'hAD);

        // nonzero id address leaves mode
        put_byte(0, 8'h70, 0);
        put_byte(0, 8'h90, 0);
        put_byte(1, 8'h05, 0);
        chk("R5 mode unchanged", io_out, 8'hE1);

        // ce_n high blocks capture
        put_byte(0, 8'h00, 0);
        put_byte(0, 8'h70, 1);
        idle(1);
        chk("R1 ce high ignored", io_out, array_data);

        // reset with busy engine: abort
        array_busy = 1'b1;
        put_byte(0, 8'hFF, 0);
        array_busy = 1'b0;
        idle(TRST + 3);
        chk("R8 mode array after reset", io_out, array_data);
        put_byte(0, 8'h70, 0);
        chk("R8 status E0", io_out, 8'hE0);

        // idle reset, second FF mid-way ignored, exact length
        low_cnt = 0;
        put_byte(0, 8'hFF, 0);
        put_byte(0, 8'hFF, 0);
        put_byte(0, 8'h70, 0);
        idle(TRST);
        chk("R9 second FF ignored, rb low count", low_cnt[7:0], 8'(TRST));
        chk("R9 70h ignored in reset", io_out, array_data);

        // write protect
        wp_n = 1'b0;
        put_byte(0, 8'hFF, 0);
        idle(TRST + 2);
        put_byte(0, 8'h70, 0);
        chk("R11 status wp low", io_out, 8'h60);
        idle(3);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!finished) begin
            finished = 1;
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule